// File: doc/BRIEF.md
# NAND Flash Command and Address Decoder

This block is the device-side front end of an asynchronous NAND flash whose commands, addresses and data share one 8-bit bus. It samples the bus on each rising edge of the active-low write strobe while the active-low chip enable is low. The command and address latch inputs mark each captured byte as a command, an address byte or a data byte. The block tracks multi-cycle sequences, collects address bytes into a 19-bit byte address, and issues single-cycle operation requests to the memory core.

Every input is sampled in the decoder's own clock domain. A strobe edge is recognised when the registered strobe level was low and the current level is high. A request appears one clock after the edge at which the strobe rise is seen, together with the address that belongs to it. The core reports work in progress through a busy input. While busy is high, only reset and status commands get through.

Top module: `nand_cmd_decoder`

## Requirements
- R1: A byte is captured only when the write strobe rises (low at one clock edge, high at the next) while chip enable is low at that edge. With chip enable high, a strobe rise has no effect.
- R2: A byte with the command latch high and the address latch low is a command. The reverse is an address byte. A byte with both latches high has no effect. A byte with both latches low is a data byte and has no effect on state or outputs.
- R3: Command 00h followed by three address bytes pulses the read request in the cycle after the third byte. The address is {high row[2:0], low row, column}, with the column byte arriving first, then the low row byte, then the high row byte. The address output changes only on accepted address bytes.
- R4: Of the high row address byte, only bits 2:0 are kept. Bits 7:3 are ignored.
- R5: Command 80h, then three address bytes, then any number of data bytes, then command 10h, pulses the program request in the cycle after the 10h byte, with the collected address.
- R6: Command 60h, then two address bytes (low row, then high row), then command D0h, pulses the erase request with a 7-bit block number equal to {high row[2:0], low row[7:4]}, which is address bits 18:12. The erase sequence leaves the column byte untouched.
- R7: Command 70h pulses the status request and command 90h pulses the ID request, each in the next cycle. Either command aborts any partly collected sequence.
- R8: Command FFh pulses the reset request and returns the decoder to idle, aborting any partly collected sequence.
- R9: While busy is high, every command other than FFh and 70h is ignored, address bytes are ignored, and the sequence state is kept unchanged.
- R10: A 10h with no completed program address, a D0h with no completed erase address, an unknown opcode, or an address byte with no read, program or erase sequence waiting for one returns the decoder to idle and produces no request.
- R11: At most one request is high in any cycle, and each request lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Decoder clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_ni | input | 1 | Active-low chip enable |
| we_ni | input | 1 | Active-low write strobe; a rise captures the bus |
| cle_i | input | 1 | Command latch enable |
| ale_i | input | 1 | Address latch enable |
| io_i | input | 8 | Multiplexed command, address and data byte |
| busy_i | input | 1 | Core busy; restricts the commands that are accepted |
| rd_req_o | output | 1 | One-cycle read request |
| prog_req_o | output | 1 | One-cycle program request |
| erase_req_o | output | 1 | One-cycle erase request |
| status_req_o | output | 1 | One-cycle status read request |
| id_req_o | output | 1 | One-cycle ID read request |
| reset_req_o | output | 1 | One-cycle reset request |
| addr_o | output | 19 | Collected byte address |
| blk_o | output | 7 | Erase block number, address bits 18:12 |

## Verification
The assertions check the following on every cycle:
- No request follows a cycle in which chip enable is high or the strobe is low.
- Requests are one-hot and last one cycle.
- Busy blocks every request except reset and status.
- The latch inputs select the class of request that can follow.
- The address output moves only after an address-latched byte.

Only the bench scenarios can show that complete sequences produce the right request with the right address or block number. The same holds for the following cases:
- the ordering of the address bytes;
- masking of the high row byte;
- aborts caused by reset and status;
- stray confirms and stray addresses being dropped;
- a confirm that is held off by busy and then accepted once busy falls.

// File: rtl/nand_dec_pkg.sv
package nand_dec_pkg;

  localparam logic [7:0] OP_READ   = 8'h00;
  localparam logic [7:0] OP_RESET  = 8'hFF;
  localparam logic [7:0] OP_PROG   = 8'h80;
  localparam logic [7:0] OP_PCONF  = 8'h10;
  localparam logic [7:0] OP_ERASE  = 8'h60;
  localparam logic [7:0] OP_ECONF  = 8'hD0;
  localparam logic [7:0] OP_STATUS = 8'h70;
  localparam logic [7:0] OP_ID     = 8'h90;

  typedef enum logic [1:0] {
    BK_NONE,
    BK_CMD,
    BK_ADDR,
    BK_DATA
  } byte_kind_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_RD_ADDR,
    SQ_PG_ADDR,
    SQ_PG_DATA,
    SQ_ER_ADDR,
    SQ_ER_CONF
  } seq_state_e;

  typedef struct packed {
    logic rd;
    logic prog;
    logic erase;
    logic status;
    logic id;
    logic rst;
  } op_req_t;

endpackage

// File: rtl/nand_bus_sampler.sv
module nand_bus_sampler
  import nand_dec_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_ni,
  input  logic          we_ni,
  input  logic          cle_i,
  input  logic          ale_i,
  input  logic [DW-1:0] io_i,
  output logic          vld_o,
  output byte_kind_e    kind_o,
  output logic [DW-1:0] byte_o
);

  logic we_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) we_q <= 1'b1;
    else         we_q <= we_ni;
  end

  // rise of strobe seen at this edge, gated by chip enable
  assign vld_o  = !we_q && we_ni && !ce_ni;
  assign byte_o = io_i;

  always_comb begin
    unique case ({cle_i, ale_i})
      2'b10:   kind_o = BK_CMD;
      2'b01:   kind_o = BK_ADDR;
      2'b00:   kind_o = BK_DATA;
      default: kind_o = BK_NONE;
    endcase
  end

endmodule

// File: rtl/nand_addr_collector.sv
module nand_addr_collector #(
  parameter int DW    = 8,
  parameter int AW    = 19,
  parameter int BLK_W = 7,
  localparam int NB   = (AW + DW - 1) / DW,
  localparam int SELW = $clog2(NB)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [SELW-1:0]  sel_i,
  input  logic [DW-1:0]    byte_i,
  output logic [AW-1:0]    addr_o,
  output logic [BLK_W-1:0] blk_o
);

  for (genvar g = 0; g < NB; g++) begin : g_lane
    localparam int LW = (g == NB - 1) ? AW - (NB - 1) * DW : DW;
    logic [LW-1:0] lane_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          lane_q <= '0;
      else if (wr_i && sel_i == SELW'(g))   lane_q <= byte_i[LW-1:0];
    end

    assign addr_o[g*DW +: LW] = lane_q;
  end

  assign blk_o = addr_o[AW-1 -: BLK_W];

endmodule

// File: rtl/nand_seq_fsm.sv
module nand_seq_fsm
  import nand_dec_pkg::*;
#(
  parameter int DW   = 8,
  parameter int AW   = 19,
  localparam int NB  = (AW + DW - 1) / DW,
  localparam int SELW = $clog2(NB)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            vld_i,
  input  byte_kind_e      kind_i,
  input  logic [DW-1:0]   byte_i,
  input  logic            busy_i,
  output logic            awr_o,
  output logic [SELW-1:0] asel_o,
  output op_req_t         req_o
);

  localparam logic [SELW-1:0] LAST_FULL = SELW'(NB - 1);
  localparam logic [SELW-1:0] LAST_ROW  = SELW'(NB - 2);

  seq_state_e      st_q, st_d;
  logic [SELW-1:0] cnt_q, cnt_d;
  op_req_t         req_d;
  logic            cmd_ok;

  assign cmd_ok = !busy_i || byte_i == OP_RESET || byte_i == OP_STATUS;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    req_d  = '0;
    awr_o  = 1'b0;
    asel_o = cnt_q;
    if (vld_i) begin
      unique case (kind_i)
        BK_CMD: if (cmd_ok) begin
          st_d  = SQ_IDLE;
          cnt_d = '0;
          unique case (byte_i)
            OP_RESET:  req_d.rst    = 1'b1;
            OP_STATUS: req_d.status = 1'b1;
            OP_ID:     req_d.id     = 1'b1;
            OP_READ:   st_d = SQ_RD_ADDR;
            OP_PROG:   st_d = SQ_PG_ADDR;
            OP_ERASE:  st_d = SQ_ER_ADDR;
            OP_PCONF:  req_d.prog  = (st_q == SQ_PG_DATA);
            OP_ECONF:  req_d.erase = (st_q == SQ_ER_CONF);
            default:   ;
          endcase
        end
        BK_ADDR: if (!busy_i) begin
          unique case (st_q)
            SQ_RD_ADDR, SQ_PG_ADDR: begin
              awr_o = 1'b1;
              if (cnt_q == LAST_FULL) begin
                cnt_d = '0;
                if (st_q == SQ_RD_ADDR) begin
                  req_d.rd = 1'b1;
                  st_d     = SQ_IDLE;
                end else begin
                  st_d = SQ_PG_DATA;
                end
              end else begin
                cnt_d = cnt_q + 1'b1;
              end
            end
            SQ_ER_ADDR: begin
              awr_o  = 1'b1;
              asel_o = cnt_q + 1'b1;  // erase skips the column lane
              if (cnt_q == LAST_ROW) begin
                cnt_d = '0;
                st_d  = SQ_ER_CONF;
              end else begin
                cnt_d = cnt_q + 1'b1;
              end
            end
            default: begin
              st_d  = SQ_IDLE;
              cnt_d = '0;
            end
          endcase
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
      req_o <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      req_o <= req_d;
    end
  end

endmodule

// File: rtl/nand_cmd_decoder.sv
module nand_cmd_decoder
  import nand_dec_pkg::*;
#(
  parameter int DW    = 8,
  parameter int AW    = 19,
  parameter int BLK_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_ni,
  input  logic             we_ni,
  input  logic             cle_i,
  input  logic             ale_i,
  input  logic [DW-1:0]    io_i,
  input  logic             busy_i,
  output logic             rd_req_o,
  output logic             prog_req_o,
  output logic             erase_req_o,
  output logic             status_req_o,
  output logic             id_req_o,
  output logic             reset_req_o,
  output logic [AW-1:0]    addr_o,
  output logic [BLK_W-1:0] blk_o
);

  localparam int NB   = (AW + DW - 1) / DW;
  localparam int SELW = $clog2(NB);

  logic            vld;
  byte_kind_e      kind;
  logic [DW-1:0]   bus_byte;
  logic            awr;
  logic [SELW-1:0] asel;
  op_req_t         req;

  nand_bus_sampler #(.DW(DW)) u_smp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ce_ni  (ce_ni),
    .we_ni  (we_ni),
    .cle_i  (cle_i),
    .ale_i  (ale_i),
    .io_i   (io_i),
    .vld_o  (vld),
    .kind_o (kind),
    .byte_o (bus_byte)
  );

  nand_seq_fsm #(.DW(DW), .AW(AW)) u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (vld),
    .kind_i (kind),
    .byte_i (bus_byte),
    .busy_i (busy_i),
    .awr_o  (awr),
    .asel_o (asel),
    .req_o  (req)
  );

  nand_addr_collector #(.DW(DW), .AW(AW), .BLK_W(BLK_W)) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (awr),
    .sel_i  (asel),
    .byte_i (bus_byte),
    .addr_o (addr_o),
    .blk_o  (blk_o)
  );

  assign rd_req_o     = req.rd;
  assign prog_req_o   = req.prog;
  assign erase_req_o  = req.erase;
  assign status_req_o = req.status;
  assign id_req_o     = req.id;
  assign reset_req_o  = req.rst;

endmodule

// File: rtl/nand_cmd_decoder_chk.sv
module nand_cmd_decoder_chk #(
  parameter int AW = 19
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ce_ni,
  input logic          we_ni,
  input logic          cle_i,
  input logic          ale_i,
  input logic          busy_i,
  input logic          rd_req_o,
  input logic          prog_req_o,
  input logic          erase_req_o,
  input logic          status_req_o,
  input logic          id_req_o,
  input logic          reset_req_o,
  input logic [AW-1:0] addr_o
);

  logic [5:0] reqs;
  assign reqs = {rd_req_o, prog_req_o, erase_req_o, status_req_o, id_req_o, reset_req_o};

  p_onehot_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(reqs));

  p_single_cycle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|reqs) |=> (reqs == '0));

  p_ce_gate_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |=> (reqs == '0));

  p_we_edge_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_ni |=> (reqs == '0));

  p_busy_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> !(rd_req_o || prog_req_o || erase_req_o || id_req_o));

  p_cmd_kind_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cle_i || ale_i) |=> !(prog_req_o || erase_req_o || status_req_o || id_req_o || reset_req_o));

  p_addr_kind_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ale_i || cle_i) |=> !rd_req_o);

  p_addr_only_on_ale_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ale_i |=> $stable(addr_o));

endmodule

bind nand_cmd_decoder nand_cmd_decoder_chk #(.AW(AW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ce_ni        (ce_ni),
  .we_ni        (we_ni),
  .cle_i        (cle_i),
  .ale_i        (ale_i),
  .busy_i       (busy_i),
  .rd_req_o     (rd_req_o),
  .prog_req_o   (prog_req_o),
  .erase_req_o  (erase_req_o),
  .status_req_o (status_req_o),
  .id_req_o     (id_req_o),
  .reset_req_o  (reset_req_o),
  .addr_o       (addr_o)
);

// File: tb/tb_nand_cmd_decoder.sv
`timescale 1ns/1ps
module tb_nand_cmd_decoder;

  localparam logic [5:0] Q_RD = 6'b100000;
  localparam logic [5:0] Q_PG = 6'b010000;
  localparam logic [5:0] Q_ER = 6'b001000;
  localparam logic [5:0] Q_ST = 6'b000100;
  localparam logic [5:0] Q_ID = 6'b000010;
  localparam logic [5:0] Q_RS = 6'b000001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1;
  logic        we_n = 1'b1;
  logic        cle = 1'b0;
  logic        ale = 1'b0;
  logic [7:0]  io = 8'h00;
  logic        busy = 1'b0;
  logic        rd, pg, er, st, id, rs;
  logic [18:0] addr;
  logic [6:0]  blk;

  int checks = 0;
  int errors = 0;
  string cur_req = "R11";

  // reference model state
  int         m_st = 0;  // 0 idle,1 rd addr,2 pg addr,3 pg data,4 er addr,5 er conf
  int         m_n = 0;
  logic [7:0] m_col = 8'h00, m_lo = 8'h00, m_hi = 8'h00;

  always #2.5 clk = ~clk;

  nand_cmd_decoder dut (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .we_ni(we_n),
    .cle_i(cle), .ale_i(ale), .io_i(io), .busy_i(busy),
    .rd_req_o(rd), .prog_req_o(pg), .erase_req_o(er),
    .status_req_o(st), .id_req_o(id), .reset_req_o(rs),
    .addr_o(addr), .blk_o(blk)
  );

  function automatic logic [18:0] m_addr();
    return {m_hi[2:0], m_lo, m_col};
  endfunction

  task automatic check(input logic [5:0] exp);
    logic [18:0] ea;
    ea = m_addr();
    checks++;
    if ({rd, pg, er, st, id, rs} !== exp) begin
      errors++;
      $display("FAIL %s: requests %b expected %b", cur_req, {rd, pg, er, st, id, rs}, exp);
    end
    checks++;
    if (addr !== ea || blk !== ea[18:12]) begin
      errors++;
      $display("FAIL %s: addr %h blk %h expected %h %h", cur_req, addr, blk, ea, ea[18:12]);
    end
  endtask

  task automatic step(input logic [5:0] exp);
    @(posedge clk);
    @(negedge clk);
    check(exp);
  endtask

  task automatic model(input logic c, input logic a, input logic [7:0] b, output logic [5:0] r);
    r = '0;
    if (ce_n) return;
    if (c && !a) begin
      if (busy && b != 8'hFF && b != 8'h70) return;
      case (b)
        8'hFF: begin r = Q_RS; m_st = 0; end
        8'h70: begin r = Q_ST; m_st = 0; end
        8'h90: begin r = Q_ID; m_st = 0; end
        8'h00: begin m_st = 1; m_n = 0; end
        8'h80: begin m_st = 2; m_n = 0; end
        8'h60: begin m_st = 4; m_n = 0; end
        8'h10: begin if (m_st == 3) r = Q_PG; m_st = 0; end
        8'hD0: begin if (m_st == 5) r = Q_ER; m_st = 0; end
        default: m_st = 0;
      endcase
    end else if (a && !c) begin
      if (busy) return;
      if (m_st == 1 || m_st == 2) begin
        if (m_n == 0) m_col = b;
        else if (m_n == 1) m_lo = b;
        else m_hi = b;
        m_n++;
        if (m_n == 3) begin
          if (m_st == 1) begin r = Q_RD; m_st = 0; end
          else m_st = 3;
        end
      end else if (m_st == 4) begin
        if (m_n == 0) m_lo = b;
        else m_hi = b;
        m_n++;
        if (m_n == 2) m_st = 5;
      end else begin
        m_st = 0;
      end
    end
  endtask

  task automatic wr(input logic c, input logic a, input logic [7:0] b);
    logic [5:0] r;
    cle = c; ale = a; io = b; we_n = 1'b0;
    step('0);
    we_n = 1'b1;
    model(c, a, b, r);
    step(r);
  endtask

  task automatic cmd(input logic [7:0] b);  wr(1'b1, 1'b0, b); endtask
  task automatic adr(input logic [7:0] b);  wr(1'b0, 1'b1, b); endtask
  task automatic dat(input logic [7:0] b);  wr(1'b0, 1'b0, b); endtask

  task automatic expect_addr(input logic [18:0] ea, input string tag);
    checks++;
    if (addr !== ea) begin
      errors++;
      $display("FAIL %s: addr %h expected %h", tag, addr, ea);
    end
  endtask

  initial begin
    #(5ns * 20000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    ce_n  = 1'b0;
    cur_req = "R11";
    step('0);  // reset state

    cur_req = "R3";  // read, column/low/high ordering; R4 masks high row
    cmd(8'h00); adr(8'h12); adr(8'h34); adr(8'hFD);
    expect_addr(19'h53412, "R4");
    step('0);

    cur_req = "R5";
    cmd(8'h80); adr(8'hA1); adr(8'hB2); adr(8'h03);
    dat(8'h10); dat(8'h55); dat(8'hD0);
    cmd(8'h10);
    expect_addr(19'h3B2A1, "R5");

    cur_req = "R6";
    cmd(8'h60); adr(8'h5A); adr(8'h07); cmd(8'hD0);
    checks++;
    if (blk !== 7'h75) begin
      errors++;
      $display("FAIL R6: blk %h expected %h", blk, 7'h75);
    end

    cur_req = "R7";
    cmd(8'h70); cmd(8'h90);
    cmd(8'h80); adr(8'h01); adr(8'h02); adr(8'h03); cmd(8'h70); cmd(8'h10);

    cur_req = "R1";
    ce_n = 1'b1; cmd(8'h70); cmd(8'h00); adr(8'h44); ce_n = 1'b0;
    cmd(8'h90);

    cur_req = "R8";
    cmd(8'h00); adr(8'h11); cmd(8'hFF); adr(8'h22);
    cmd(8'h60); adr(8'h33); cmd(8'hFF); cmd(8'hD0);

    cur_req = "R9";
    busy = 1'b1;
    cmd(8'h00); adr(8'h66); cmd(8'h90); cmd(8'h70); cmd(8'hFF);
    busy = 1'b0;
    cmd(8'h80); adr(8'h0C); adr(8'h0D); adr(8'h0E);
    busy = 1'b1; cmd(8'h10); adr(8'h77); busy = 1'b0;
    cmd(8'h10);
    expect_addr(19'h60D0C, "R9");

    cur_req = "R10";
    cmd(8'h10); cmd(8'hD0); adr(8'h99);
    cmd(8'h60); adr(8'h40); adr(8'h01); cmd(8'h10); cmd(8'hD0);
    cmd(8'h80); adr(8'h01); cmd(8'h10); adr(8'h02);
    cmd(8'h00); cmd(8'h3C); adr(8'h04); adr(8'h05);

    cur_req = "R2";
    wr(1'b1, 1'b1, 8'h70); dat(8'h70);
    cmd(8'h00); dat(8'hAA); adr(8'h21); wr(1'b1, 1'b1, 8'hFF); adr(8'h43); adr(8'h05);
    expect_addr(19'h54321, "R2");

    cur_req = "R11";
    repeat (4) step('0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule